// File: doc/BRIEF.md
# Ordered Commit Arbiter

This block decides which of several processors may broadcast its commit packet on the shared interconnect next. Only one commit may be in flight system-wide, so the arbiter hands out a single grant and keeps it until the granted processor signals the last beat of its packet.

Each requester raises a request together with two tags: an ordering group (sequence) and a position inside that group (phase). Requests in different groups have no order between them. Inside one group, only the requests carrying the smallest phase among those currently asking may win. Requests with the same phase in one group have no order between them either. All eligible requests are served round-robin, so a stream of unordered commits cannot starve anyone.

The decision is made from the request and tag inputs in the cycle it is taken. The winner is registered at the next clock edge. After the owner's end-of-packet beat, the grant drops for one cycle while a fresh decision is taken.

Top module: `sp_commit_arb`

## Requirements
- R1: At most one bit of `gnt_o` is ever set, and `busy_o` is high exactly while a grant is held.
- R2: While reset is asserted and directly after it, `gnt_o` is all zeros and `busy_o` is low.
- R3: When the arbiter is idle and at least one request is eligible in a cycle, the winner's bit of `gnt_o` (bit i for requester i) is set after the next rising clock edge.
- R4: A request is not eligible while another active request has the same sequence tag and a strictly smaller phase tag (tags compared as unsigned numbers).
- R5: Requests with different sequence tags never block one another, whatever their phase tags.
- R6: Once set, the grant stays unchanged, even if requests are withdrawn or new ones arrive, until the owner's `eop_i` bit is high.
- R7: An `eop_i` bit from the owner clears `gnt_o` at the next edge. A decision is taken in the cycle after that, so a new grant can appear one edge later.
- R8: `eop_i` bits from requesters that do not hold the grant have no effect.
- R9: Among eligible requests, the search starts at the requester after the last winner, wrapping from N-1 to 0.
- R10: Eligible requests with equal sequence and equal phase tags are served round-robin.
- R11: A request withdrawn in the cycle a decision is taken is not granted in that decision.
- R12: After reset the round-robin search starts at requester 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_REQ | Commit request, one bit per processor |
| seq_i | input | N_REQ*SEQ_W | Sequence tag of each requester; requester i uses bits [i*SEQ_W +: SEQ_W] |
| phase_i | input | N_REQ*PH_W | Phase tag of each requester; requester i uses bits [i*PH_W +: PH_W] |
| eop_i | input | N_REQ | Last beat of the commit packet, one bit per processor |
| gnt_o | output | N_REQ | One-hot commit grant |
| busy_o | output | 1 | A grant is held |

## Verification
The bench sets up three phases in one group where the lowest-phase request is not the first in round-robin order. A design that ignored phases would grant the wrong processor first. A request with a higher phase in another group must win while a same-group request waits; a design that compared phases across groups would hold it back. End-of-packet pulses from processors that do not own the grant, and requests dropped while a grant is held, must leave the grant untouched; a design that released on any end-of-packet would cut a packet short. A request withdrawn in the decision cycle, and a round-robin wrap among equal tags, expose a design that registers requests late or restarts its search at a fixed requester.

// File: rtl/sp_commit_pkg.sv
package sp_commit_pkg;
    localparam int unsigned DEF_N_REQ = 4;
    localparam int unsigned DEF_SEQ_W = 3;
    localparam int unsigned DEF_PH_W  = 4;

    // Next round-robin start after a winner at index idx among n requesters.
    function automatic int unsigned rr_after(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/sp_elig_calc.sv
module sp_elig_calc #(
    parameter int unsigned N_REQ = 4,
    parameter int unsigned SEQ_W = 3,
    parameter int unsigned PH_W  = 4
) (
    input  logic [N_REQ-1:0]       req,
    input  logic [N_REQ*SEQ_W-1:0] seq,
    input  logic [N_REQ*PH_W-1:0]  phase,
    output logic [N_REQ-1:0]       elig
);
    for (genvar gi = 0; gi < N_REQ; gi++) begin : g_req
        logic blocked;
        always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < N_REQ; j++) begin
                if (j != gi && req[j]
                    && seq[j*SEQ_W +: SEQ_W] == seq[gi*SEQ_W +: SEQ_W]
                    && phase[j*PH_W +: PH_W] < phase[gi*PH_W +: PH_W]) begin
                    blocked = 1'b1;
                end
            end
            elig[gi] = req[gi] && !blocked;
        end
    end
endmodule

// File: rtl/sp_rr_pick.sv
module sp_rr_pick #(
    parameter int unsigned N_REQ = 4,
    localparam int unsigned IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] elig,
    input  logic [IW-1:0]    start,
    output logic [N_REQ-1:0] win_oh,
    output logic [IW-1:0]    win_idx,
    output logic             win_any
);
    always_comb begin
        win_oh  = '0;
        win_idx = '0;
        win_any = 1'b0;
        for (int off = 0; off < N_REQ; off++) begin
            int p;
            p = (int'(start) + off) % N_REQ;
            if (!win_any && elig[p]) begin
                win_any    = 1'b1;
                win_idx    = IW'(p);
                win_oh[p]  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_commit_arb.sv
module sp_commit_arb
    import sp_commit_pkg::*;
#(
    parameter int unsigned N_REQ = DEF_N_REQ,
    parameter int unsigned SEQ_W = DEF_SEQ_W,
    parameter int unsigned PH_W  = DEF_PH_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_REQ-1:0]       req_i,
    input  logic [N_REQ*SEQ_W-1:0] seq_i,
    input  logic [N_REQ*PH_W-1:0]  phase_i,
    input  logic [N_REQ-1:0]       eop_i,
    output logic [N_REQ-1:0]       gnt_o,
    output logic                   busy_o
);
    localparam int unsigned IW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    typedef struct packed {
        logic             busy;
        logic [N_REQ-1:0] gnt;
        logic [IW-1:0]    owner;
        logic [IW-1:0]    ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [N_REQ-1:0] elig;
    logic [N_REQ-1:0] win_oh;
    logic [IW-1:0]    win_idx;
    logic             win_any;

    sp_elig_calc #(.N_REQ(N_REQ), .SEQ_W(SEQ_W), .PH_W(PH_W)) u_elig (
        .req   (req_i),
        .seq   (seq_i),
        .phase (phase_i),
        .elig  (elig)
    );

    sp_rr_pick #(.N_REQ(N_REQ)) u_pick (
        .elig    (elig),
        .start   (st_q.ptr),
        .win_oh  (win_oh),
        .win_idx (win_idx),
        .win_any (win_any)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (eop_i[st_q.owner]) begin
                st_d.busy = 1'b0;
                st_d.gnt  = '0;
            end
        end else if (win_any) begin
            st_d.busy  = 1'b1;
            st_d.gnt   = win_oh;
            st_d.owner = win_idx;
            st_d.ptr   = IW'(rr_after(int'(win_idx), N_REQ));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_o  = st_q.gnt;
    assign busy_o = st_q.busy;
endmodule

// File: rtl/sp_commit_arb_chk.sv
module sp_commit_arb_chk #(
    parameter int unsigned N_REQ = 4,
    parameter int unsigned SEQ_W = 3,
    parameter int unsigned PH_W  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_REQ-1:0]       req_i,
    input logic [N_REQ*SEQ_W-1:0] seq_i,
    input logic [N_REQ*PH_W-1:0]  phase_i,
    input logic [N_REQ-1:0]       eop_i,
    input logic [N_REQ-1:0]       gnt_o,
    input logic                   busy_o
);
    logic [N_REQ-1:0]       prev_req, prev_gnt;
    logic [N_REQ*SEQ_W-1:0] prev_seq;
    logic [N_REQ*PH_W-1:0]  prev_ph;
    logic                   order_bad;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_req <= '0;
            prev_gnt <= '0;
            prev_seq <= '0;
            prev_ph  <= '0;
        end else begin
            prev_req <= req_i;
            prev_gnt <= gnt_o;
            prev_seq <= seq_i;
            prev_ph  <= phase_i;
        end
    end

    always_comb begin
        order_bad = 1'b0;
        if (prev_gnt == '0) begin
            for (int i = 0; i < N_REQ; i++) begin
                for (int j = 0; j < N_REQ; j++) begin
                    if (gnt_o[i] && j != i && prev_req[j]
                        && prev_seq[j*SEQ_W +: SEQ_W] == prev_seq[i*SEQ_W +: SEQ_W]
                        && prev_ph[j*PH_W +: PH_W] < prev_ph[i*PH_W +: PH_W]) begin
                        order_bad = 1'b1;
                    end
                end
            end
        end
    end

    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o) && (busy_o == (gnt_o != '0)));

    p_reset_idle_r2: assert property (@(posedge clk)
        !rst_n |-> (gnt_o == '0 && !busy_o));

    p_phase_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !order_bad);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && (gnt_o & eop_i) == '0) |=> $stable(gnt_o));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt_o & eop_i) != '0) |=> (gnt_o == '0 && !busy_o));

    p_grant_requested_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0) |=> (gnt_o == '0 || (gnt_o & $past(req_i)) != '0));
endmodule

bind sp_commit_arb sp_commit_arb_chk #(.N_REQ(N_REQ), .SEQ_W(SEQ_W), .PH_W(PH_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .seq_i   (seq_i),
    .phase_i (phase_i),
    .eop_i   (eop_i),
    .gnt_o   (gnt_o),
    .busy_o  (busy_o)
);

// File: tb/sp_commit_arb_tb.sv
module sp_commit_arb_tb;
    localparam int N = 4;
    localparam int SW = 3;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  req;
    logic [N*SW-1:0] seq;
    logic [N*PW-1:0] ph;
    logic [N-1:0]  eop;
    logic [N-1:0]  gnt;
    logic          busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sp_commit_arb #(.N_REQ(N), .SEQ_W(SW), .PH_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .seq_i(seq), .phase_i(ph),
        .eop_i(eop), .gnt_o(gnt), .busy_o(busy)
    );

    task automatic cyc(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [N-1:0] exp_g, input logic exp_b);
        checks++;
        if (gnt !== exp_g || busy !== exp_b) begin
            errors++;
            $display("FAIL %s: gnt=%b busy=%b expected gnt=%b busy=%b", tag, gnt, busy, exp_g, exp_b);
        end
    endtask

    task automatic set_req(input int i, input int s, input int p);
        req[i] = 1'b1;
        seq[i*SW +: SW] = SW'(s);
        ph[i*PW +: PW] = PW'(p);
    endtask

    task automatic do_reset();
        req = '0; seq = '0; ph = '0; eop = '0;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
        cyc(1);
    endtask

    // owner i finishes: eop pulse, request dropped
    task automatic finish(input int i, input bit keep_req = 0);
        eop[i] = 1'b1;
        if (!keep_req) req[i] = 1'b0;
        cyc(1);
        eop[i] = 1'b0;
    endtask

    task automatic t_reset();
        req = '0; seq = '0; ph = '0; eop = '0;
        rst_n = 1'b0;
        cyc(1);
        chk("R2 in reset", 4'b0000, 1'b0);
        set_req(1, 0, 0);
        cyc(1);
        chk("R2 reset holds off grant", 4'b0000, 1'b0);
        do_reset();
        chk("R2 after reset", 4'b0000, 1'b0);
    endtask

    task automatic t_single();
        do_reset();
        set_req(0, 1, 2);
        cyc(1);
        chk("R3 grant after one edge", 4'b0001, 1'b1);
        req[0] = 1'b0;
        set_req(2, 5, 0);
        cyc(3);
        chk("R6 held despite withdraw and new request", 4'b0001, 1'b1);
        finish(0);
        chk("R7 release after eop", 4'b0000, 1'b0);
        cyc(1);
        chk("R7 new decision next cycle", 4'b0100, 1'b1);
    endtask

    task automatic t_phase();
        do_reset();
        set_req(0, 2, 5);
        set_req(1, 2, 3);
        set_req(2, 2, 7);
        cyc(1);
        chk("R4 lowest phase first", 4'b0010, 1'b1);
        finish(1);
        chk("R7 idle gap", 4'b0000, 1'b0);
        cyc(1);
        chk("R4 next lowest phase", 4'b0001, 1'b1);
        finish(0);
        cyc(1);
        chk("R4 last phase", 4'b0100, 1'b1);
    endtask

    task automatic t_seq_indep();
        do_reset();
        set_req(0, 1, 9);
        set_req(1, 1, 1);
        set_req(2, 3, 15);
        cyc(1);
        chk("R4 low phase beats rr order", 4'b0010, 1'b1);
        finish(1);
        cyc(1);
        chk("R5 other sequence not blocked", 4'b0100, 1'b1);
    endtask

    task automatic t_rr_equal();
        do_reset();
        set_req(0, 4, 2);
        set_req(1, 4, 2);
        set_req(3, 4, 2);
        cyc(1);
        chk("R12 search starts at 0", 4'b0001, 1'b1);
        finish(0, 1);
        cyc(1);
        chk("R10 equal tags rotate", 4'b0010, 1'b1);
        finish(1, 1);
        cyc(1);
        chk("R9 skip idle requester", 4'b1000, 1'b1);
        finish(3, 1);
        cyc(1);
        chk("R9 wrap to 0", 4'b0001, 1'b1);
    endtask

    task automatic t_foreign_eop();
        do_reset();
        set_req(2, 0, 0);
        cyc(1);
        chk("R3 grant 2", 4'b0100, 1'b1);
        set_req(0, 1, 0);
        eop = 4'b1011;
        cyc(1);
        chk("R8 foreign eop ignored", 4'b0100, 1'b1);
        eop = '0;
        cyc(1);
        chk("R8 still held", 4'b0100, 1'b1);
    endtask

    task automatic t_withdraw();
        do_reset();
        set_req(3, 6, 0);
        cyc(1);
        chk("R3 grant 3", 4'b1000, 1'b1);
        set_req(0, 1, 1);
        cyc(1);
        finish(3);
        chk("R7 released", 4'b0000, 1'b0);
        req[0] = 1'b0;
        set_req(2, 1, 1);
        cyc(1);
        chk("R11 withdrawn request skipped", 4'b0100, 1'b1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_phase();
        t_seq_indep();
        t_rr_equal();
        t_foreign_eop();
        t_withdraw();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule